// File: doc/BRIEF.md
# Multicycle Unsigned Byte Divider

This execution unit divides a 16-bit unsigned dividend by an 8-bit unsigned divisor with a restoring shift-subtract loop that produces one quotient bit per clock. A one-cycle start pulse captures both operands and the incoming condition-code bits. Exactly fourteen cycles later the unit raises a one-cycle done pulse. In that same cycle it presents a packed 16-bit result and an updated 5-bit condition-code word.

The packed result holds the remainder in its upper byte and the quotient in its lower byte. The condition codes do not depend on the result. The sign and zero bits are taken from the divisor alone, and the other three bits are returned exactly as they were supplied.

A divide by zero still takes the full fourteen cycles and gives a fixed, repeatable result. A separate overflow output tells a checker when the quotient would not fit in eight bits. That output has no effect on the condition codes.

Top module: `bytediv_unit`

## Requirements
- R1: When the divisor d is non-zero and dividend[15:8] < d, result_o[7:0] equals floor(dividend / d) and result_o[15:8] equals dividend mod d.
- R2: ccr_o bit 3 (sign) equals bit 7 of the divisor.
- R3: ccr_o bit 2 (zero) is 1 exactly when the divisor is 0x00.
- R4: ccr_o bits 4, 1 and 0 equal ccr_i bits 4, 1 and 0 as sampled with the accepted start.
- R5: done_o is high for exactly one cycle, 14 clock edges after the edge that accepted start_i. The result_o, ccr_o and ovf_o values are valid in that cycle.
- R6: A start_i asserted while an operation is in progress is ignored. It changes neither the running result nor its timing, and it does not begin a second operation.
- R7: Operands are sampled only at an accepted start. Between done pulses, result_o, ccr_o and ovf_o hold their values whatever the inputs do.
- R8: With a divisor of 0x00, result_o equals {dividend[7:0], 8'hFF}.
- R9: ovf_o is 1 exactly when dividend[15:8] >= divisor. It never alters ccr_o bit 1.
- R10: While rst_n is low, result_o, ccr_o, done_o and ovf_o are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a divide; ignored while busy |
| dividend_i | input | 16 | Unsigned dividend |
| divisor_i | input | 8 | Unsigned divisor |
| ccr_i | input | 5 | Incoming flags {H,N,Z,V,C} in bits 4..0 |
| result_o | output | 16 | {remainder, quotient} |
| ccr_o | output | 5 | Updated flags {H,N,Z,V,C} |
| done_o | output | 1 | One-cycle completion pulse |
| ovf_o | output | 1 | Quotient would exceed eight bits, or divisor is zero |

## Verification
On every cycle, the assertions check the following:
- the width of the done pulse and its distance from the accepted start, counted independently;
- that outputs hold between completions;
- that the sign and zero flags agree with the captured divisor;
- the bound remainder < divisor during and after a non-overflowing divide;
- the all-ones quotient on a divide by zero;
- that a start raised while busy leaves the captured divisor alone.

Only the bench scenarios can show the following:
- the exact quotient and remainder values against arithmetic division over a sweep of every divisor;
- the pass-through of H, V and C;
- the overflow indication;
- that inputs scrambled after the start have no effect.

// File: rtl/bytediv_pkg.sv
`timescale 1ns/1ps
package bytediv_pkg;
   localparam int FLAG_W = 5;
   localparam int FLAG_C = 0;
   localparam int FLAG_V = 1;
   localparam int FLAG_Z = 2;
   localparam int FLAG_N = 3;
   localparam int FLAG_H = 4;
endpackage

// File: rtl/bytediv_seq.sv
`timescale 1ns/1ps
module bytediv_seq #(
   parameter int LATENCY = 14,
   parameter int STEPS   = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic busy_o,
   output logic load_o,
   output logic step_o,
   output logic finish_o,
   output logic done_o
);
   localparam int CW = $clog2(LATENCY + 1);

   logic [CW-1:0] cnt_q;
   logic          busy_q;
   logic          done_q;

   assign load_o   = start_i && !busy_q;
   assign step_o   = busy_q && (cnt_q != '0) && (cnt_q <= CW'(STEPS));
   assign finish_o = busy_q && (cnt_q == CW'(LATENCY));
   assign busy_o   = busy_q;
   assign done_o   = done_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         busy_q <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= finish_o;
         if (load_o) begin
            busy_q <= 1'b1;
            cnt_q  <= CW'(1);
         end else if (finish_o) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
         end else if (busy_q) begin
            cnt_q  <= cnt_q + CW'(1);
         end
      end
   end

   // R5: busy never outlives the completion edge
   assert_busy_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
      finish_o |=> !busy_q);
endmodule

// File: rtl/bytediv_core.sv
`timescale 1ns/1ps
module bytediv_core #(
   parameter int DVD_W = 16,
   parameter int DVS_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic             step_i,
   input  logic             finish_i,
   input  logic [DVD_W-1:0] dividend_i,
   input  logic [DVS_W-1:0] divisor_i,
   output logic [DVD_W-1:0] result_o,
   output logic             ovf_o,
   output logic [DVS_W-1:0] dvs_o
);
   localparam int QW = DVD_W - DVS_W;

   logic [DVS_W-1:0] dvs_q;
   logic [DVS_W-1:0] part_q;
   logic [QW-1:0]    quo_q;
   logic [DVS_W-1:0] dzrem_q;
   logic             ovf_pend_q;
   logic [DVD_W-1:0] result_q;
   logic             ovf_q;

   logic [DVS_W:0]   shifted;
   logic [DVS_W:0]   trial;
   logic             take;

   assign shifted = {part_q, quo_q[QW-1]};
   assign take    = (shifted >= {1'b0, dvs_q});
   assign trial   = shifted - {1'b0, dvs_q};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dvs_q      <= '0;
         part_q     <= '0;
         quo_q      <= '0;
         dzrem_q    <= '0;
         ovf_pend_q <= 1'b0;
         result_q   <= '0;
         ovf_q      <= 1'b0;
      end else begin
         if (load_i) begin
            dvs_q      <= divisor_i;
            part_q     <= dividend_i[DVD_W-1:QW];
            quo_q      <= dividend_i[QW-1:0];
            dzrem_q    <= dividend_i[DVS_W-1:0];
            ovf_pend_q <= (dividend_i[DVD_W-1:QW] >= divisor_i);
         end else if (step_i) begin
            part_q <= take ? trial[DVS_W-1:0] : shifted[DVS_W-1:0];
            quo_q  <= {quo_q[QW-2:0], take};
         end
         if (finish_i) begin
            ovf_q <= ovf_pend_q;
            if (dvs_q == '0)
               result_q <= {dzrem_q, {QW{1'b1}}};
            else
               result_q <= {part_q, quo_q};
         end
      end
   end

   assign result_o = result_q;
   assign ovf_o    = ovf_q;
   assign dvs_o    = dvs_q;

   // R1: partial remainder stays below the divisor on every non-overflowing step
   assert_part_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !ovf_pend_q) |=> (part_q < dvs_q));
endmodule

// File: rtl/bytediv_flags.sv
`timescale 1ns/1ps
module bytediv_flags
   import bytediv_pkg::*;
#(
   parameter int DVS_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic              finish_i,
   input  logic [FLAG_W-1:0] ccr_i,
   input  logic [DVS_W-1:0]  divisor_i,
   output logic [FLAG_W-1:0] ccr_o
);
   logic [FLAG_W-1:0] next_flags;
   logic [FLAG_W-1:0] pend_q;
   logic [FLAG_W-1:0] out_q;

   for (genvar b = 0; b < FLAG_W; b++) begin : g_bit
      if (b == FLAG_N) begin : g_sign
         assign next_flags[b] = divisor_i[DVS_W-1];
      end else if (b == FLAG_Z) begin : g_zero
         assign next_flags[b] = (divisor_i == '0);
      end else begin : g_keep
         assign next_flags[b] = ccr_i[b];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= '0;
         out_q  <= '0;
      end else begin
         if (load_i)   pend_q <= next_flags;
         if (finish_i) out_q  <= pend_q;
      end
   end

   assign ccr_o = out_q;

   // R4: kept flags published at completion match what was captured
   assert_keep_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
      finish_i |=> (out_q[FLAG_H] == $past(pend_q[FLAG_H]) &&
                    out_q[FLAG_V] == $past(pend_q[FLAG_V]) &&
                    out_q[FLAG_C] == $past(pend_q[FLAG_C])));
endmodule

// File: rtl/bytediv_unit.sv
`timescale 1ns/1ps
module bytediv_unit
   import bytediv_pkg::*;
#(
   parameter int DVD_W   = 16,
   parameter int DVS_W   = 8,
   parameter int LATENCY = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [DVD_W-1:0]  dividend_i,
   input  logic [DVS_W-1:0]  divisor_i,
   input  logic [FLAG_W-1:0] ccr_i,
   output logic [DVD_W-1:0]  result_o,
   output logic [FLAG_W-1:0] ccr_o,
   output logic              done_o,
   output logic              ovf_o
);
   localparam int QW = DVD_W - DVS_W;
   localparam int CW = $clog2(LATENCY + 1);

   if (QW < 2) begin : g_bad_width
      $error("bytediv_unit: dividend must be at least two bits wider than divisor");
   end
   if (LATENCY < QW + 2) begin : g_bad_latency
      $error("bytediv_unit: LATENCY too small for the iteration count");
   end

   logic             busy, load, step, finish;
   logic [DVS_W-1:0] cap_dvs;

   bytediv_seq #(.LATENCY(LATENCY), .STEPS(QW)) u_seq (
      .clk(clk), .rst_n(rst_n), .start_i(start_i),
      .busy_o(busy), .load_o(load), .step_o(step),
      .finish_o(finish), .done_o(done_o)
   );

   bytediv_core #(.DVD_W(DVD_W), .DVS_W(DVS_W)) u_core (
      .clk(clk), .rst_n(rst_n), .load_i(load), .step_i(step),
      .finish_i(finish), .dividend_i(dividend_i), .divisor_i(divisor_i),
      .result_o(result_o), .ovf_o(ovf_o), .dvs_o(cap_dvs)
   );

   bytediv_flags #(.DVS_W(DVS_W)) u_flags (
      .clk(clk), .rst_n(rst_n), .load_i(load), .finish_i(finish),
      .ccr_i(ccr_i), .divisor_i(divisor_i), .ccr_o(ccr_o)
   );

   // independent age counter from accepted start to completion
   logic          chk_run;
   logic [CW-1:0] chk_age;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         chk_run <= 1'b0;
         chk_age <= '0;
      end else if (done_o) begin
         chk_run <= start_i;
         chk_age <= '0;
      end else if (start_i && !chk_run) begin
         chk_run <= 1'b1;
         chk_age <= '0;
      end else if (chk_run) begin
         chk_age <= chk_age + CW'(1);
      end
   end

   assert_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (chk_run && chk_age == CW'(LATENCY)));
   assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> ($stable(result_o) && $stable(ccr_o) && $stable(ovf_o)));
   assert_sign_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (ccr_o[FLAG_N] == cap_dvs[DVS_W-1]));
   assert_zero_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (ccr_o[FLAG_Z] == (cap_dvs == '0)));
   assert_rem_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !ovf_o) |-> (result_o[DVD_W-1:QW] < cap_dvs));
   assert_dz_quot_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && cap_dvs == '0) |-> (result_o[QW-1:0] == {QW{1'b1}}));
   assert_busy_ignore_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start_i) |=> $stable(cap_dvs));
   assert_reset_R10: assert property (@(posedge clk)
      !rst_n |=> (result_o == '0 && ccr_o == '0 && !done_o && !ovf_o));
endmodule

// File: tb/bytediv_unit_tb.sv
`timescale 1ns/1ps
module bytediv_unit_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [15:0] dvd = '0;
   logic [7:0]  dvs = '0;
   logic [4:0]  ccr_in = '0;
   logic [15:0] res;
   logic [4:0]  ccr_out;
   logic        done, ovf;
   int          n_chk = 0;
   int          n_fail = 0;

   always #2.5 clk = ~clk;

   bytediv_unit u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start), .dividend_i(dvd),
      .divisor_i(dvs), .ccr_i(ccr_in), .result_o(res), .ccr_o(ccr_out),
      .done_o(done), .ovf_o(ovf)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic run_op(input logic [15:0] a, input logic [7:0] d, input logic [4:0] f);
      int          early = 0;
      logic [15:0] q16, r16, exp_res;
      logic [4:0]  exp_ccr;
      @(negedge clk);
      chk(done == 1'b0, "R5 done one cycle", 32'(done), 32'd0);
      start = 1'b1; dvd = a; dvs = d; ccr_in = f;
      for (int k = 1; k <= 14; k++) begin
         @(negedge clk);
         if (k == 1) begin
            start = 1'b0; dvd = ~a; dvs = ~d; ccr_in = ~f; // R7 capture only at start
         end
         if (done) early++;
      end
      @(negedge clk);
      chk(done == 1'b1 && early == 0, "R5 latency 14", {early[15:0], 15'd0, done}, 32'd1);
      exp_ccr = {f[4], d[7], (d == 8'h00), f[1], f[0]};
      chk(ccr_out[3] == exp_ccr[3], "R2 sign flag", 32'(ccr_out), 32'(exp_ccr));
      chk(ccr_out[2] == exp_ccr[2], "R3 zero flag", 32'(ccr_out), 32'(exp_ccr));
      chk(ccr_out[4] == f[4] && ccr_out[1:0] == f[1:0], "R4 kept flags",
          32'(ccr_out), 32'(exp_ccr));
      chk(ovf == (a[15:8] >= d), "R9 overflow", 32'(ovf), 32'(a[15:8] >= d));
      if (d == 8'h00) begin
         exp_res = {a[7:0], 8'hFF};
         chk(res == exp_res, "R8 divide by zero", 32'(res), 32'(exp_res));
      end else if (a[15:8] < d) begin
         q16 = a / {8'd0, d};
         r16 = a % {8'd0, d};
         exp_res = {r16[7:0], q16[7:0]};
         chk(res == exp_res, "R1 quotient/remainder", 32'(res), 32'(exp_res));
      end
   endtask

   initial begin
      #975000;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [15:0] hold_res;
      logic [4:0]  hold_ccr;
      logic        hold_ovf;
      int          late;
      int          early;
      repeat (4) @(negedge clk);
      // R10 reset state
      chk(res == 16'h0 && ccr_out == 5'h0 && !done && !ovf, "R10 reset outputs",
          {res, 11'd0, ccr_out}, 32'd0);
      rst_n = 1'b1;

      // directed corners
      run_op(16'h1234, 8'h56, 5'b10101);
      run_op(16'hFEFF, 8'hFF, 5'b01010);
      run_op(16'h7FFF, 8'h80, 5'b11111);
      run_op(16'hABCD, 8'h00, 5'b00000);
      run_op(16'h0000, 8'h01, 5'b10010);
      run_op(16'hFFFF, 8'hFF, 5'b00011);
      run_op(16'h0000, 8'h00, 5'b11011);

      // R6 start while busy is ignored
      early = 0;
      @(negedge clk);
      start = 1'b1; dvd = 16'h0C35; dvs = 8'h25; ccr_in = 5'b10011;
      for (int k = 1; k <= 14; k++) begin
         @(negedge clk);
         if (k == 1) start = 1'b0;
         if (k == 5) begin start = 1'b1; dvd = 16'h0010; dvs = 8'h02; ccr_in = 5'b00000; end
         if (k == 6) start = 1'b0;
         if (done) early++;
      end
      @(negedge clk);
      chk(done && early == 0, "R6 timing unaffected", 32'(early), 32'd0);
      chk(res == {8'd17, 8'd84}, "R6 result unaffected", 32'(res), 32'h1154);
      chk(ccr_out == 5'b10011, "R6 flags unaffected", 32'(ccr_out), 32'h13);
      late = 0;
      for (int k = 0; k < 16; k++) begin
         @(negedge clk);
         if (done) late++;
      end
      chk(late == 0, "R6 no second operation", 32'(late), 32'd0);

      // sweep of every divisor
      for (int d = 0; d < 256; d++) begin
         for (int i = 0; i < 32; i++) begin
            int          m;
            logic [15:0] a;
            m = (i * 12059) ^ (d << 5) ^ (i << 11);
            a = m[15:0];
            if (i[0] == 1'b0 && d != 0) a[15:8] = a[15:8] % d[7:0];
            run_op(a, d[7:0], m[20:16]);
         end
      end

      // R7 outputs hold while inputs move
      hold_res = res; hold_ccr = ccr_out; hold_ovf = ovf;
      late = 0;
      for (int k = 0; k < 8; k++) begin
         @(negedge clk);
         dvd = dvd + 16'h1357; dvs = dvs + 8'h2B; ccr_in = ~ccr_in;
         if (done) late++;
      end
      @(negedge clk);
      chk(res == hold_res && ccr_out == hold_ccr && ovf == hold_ovf && late == 0,
          "R7 outputs held", 32'(res), 32'(hold_res));

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule